// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block produces a repeating interrupt for a real-time clock subsystem. A one-cycle strobe at the 32768 Hz reference rate enters a free-running prescaler. A 4-bit select field picks a tick rate of 32768 / 2^n from the prescaler. At each tick a down-counter loaded from a programmable reload value steps down by one. When the counter expires, a sticky pending flag and the interrupt line are raised. The counter then reloads itself and keeps running.

Control arrives as level fields: a master enable, a tick enable and the rate select. The reload value is written through a one-cycle write port that refuses values too small to be useful. Software acknowledges the interrupt by writing a one to the pending bit through a write-one-to-clear port. The live counter value is always visible on an output.

The core is a two-state machine. In `ST_STOPPED` the counter holds its value. Transition `t_start` moves the machine to `ST_COUNTING` and loads the counter. While counting, `t_step` decrements the counter and `t_expire` reloads it and raises the pending flag. Transition `t_halt` returns the machine to `ST_STOPPED`.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter reads 0, the pending flag and interrupt are low, and the timer is stopped.
- R2: With select value n, the prescaler emits a tick on every 2^n-th reference strobe, counted from reset (the k·2^n-th strobe, k = 1, 2, ...). A running counter changes only on such ticks.
- R3: A reload write is accepted only when the written value is greater than 2. Any other value leaves the previous reload value in place.
- R4: The counter is loaded with the reload value and starts (`t_start`) only in a cycle where the tick enable is 1 and was 0 in the previous cycle, the master enable is 1, and the reload value is nonzero. The load appears on the output after that edge. A rise of the master enable alone never starts the timer.
- R5: If either the tick enable or the master enable is 0 while counting, the timer stops (`t_halt`). A stopped counter holds its value.
- R6: A tick that arrives while the counter reads 1 (`t_expire`) reloads the counter with the reload value and sets the pending flag, so the period is the reload value in ticks. Any other tick while running (`t_step`) subtracts one from the counter.
- R7: A pending write with data 1 clears the pending flag on the next edge. A pending write with data 0 changes nothing.
- R8: If an expiry and a clearing write fall in the same cycle, the pending flag ends up set.
- R9: The interrupt output always equals the pending flag.
- R10: A reload write while counting does not change the current count. The new value is used at the next load or expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| master_en | input | 1 | Master clock enable field |
| tick_en | input | 1 | Tick timer enable field; its rising edge starts the timer |
| div_sel | input | SEL_W (4) | Rate select n, tick rate = 32768 / 2^n |
| reload_wr | input | 1 | Reload value write strobe |
| reload_wdata | input | CNT_W (16) | Reload value write data |
| pend_wr | input | 1 | Pending flag write strobe |
| pend_wdata | input | 1 | Pending write data; 1 clears the flag |
| tick_irq | output | 1 | Tick interrupt line |
| tick_pending | output | 1 | Pending status flag |
| tick_count | output | CNT_W (16) | Live down-counter value |

## Verification
Two functions can land on the same edge. One is the expiry that sets the pending flag; the other is a software write that clears it. The bench counts the counter down with a tick on every reference strobe and places a clearing write exactly in the cycle where the counter reads 1. It then expects the counter to be reloaded and the pending flag and interrupt still high. A long stretch of pseudo-random enables, reload writes, clears and strobes is compared against a cycle model built from the requirements. This stretch also covers collisions between a start and a tick, and between a reload write and an expiry.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // Operating states of the tick down-counter
    typedef enum logic [0:0] {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } tick_state_e;

    // Reference rate the prescaler divides
    localparam int unsigned REF_RATE_HZ = 32768;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_stb,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick_stb
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] sel_mask;

    // Bit i of the mask is set when it lies below the selected power of two
    generate
        for (genvar i = 0; i < PRE_W; i++) begin : g_mask
            assign sel_mask[i] = (int'(div_sel) > i);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (ref_stb) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // A tick fires on the strobe that completes a group of 2^n strobes
    assign tick_stb = ref_stb & (&(pre_q | ~sel_mask));

endmodule

// File: rtl/tick_reload_reg.sv
module tick_reload_reg #(
    parameter int CNT_W      = 16,
    parameter int MIN_RELOAD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] reload_q
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

    logic accept;

    // Values at or below the floor are refused and the old value stays
    assign accept = wr && (wdata > FLOOR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (accept) begin
            reload_q <= wdata;
        end
    end

endmodule

// File: rtl/tick_down_fsm.sv
module tick_down_fsm
    import tick_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             tick_en,
    input  logic             tick_stb,
    input  logic [CNT_W-1:0] reload,
    output logic             running,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tick_state_e      state_q;
    tick_state_e      state_d;
    logic             ten_q;
    logic [CNT_W-1:0] cnt_q;
    logic             gate;
    logic             arm;
    logic             t_start;
    logic             t_halt;
    logic             t_expire;
    logic             t_step;

    assign gate = master_en & tick_en;
    assign arm  = tick_en & ~ten_q & master_en & (reload != '0);

    // Transition decode
    always_comb begin
        state_d  = state_q;
        t_start  = 1'b0;
        t_halt   = 1'b0;
        t_expire = 1'b0;
        t_step   = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                if (arm) begin
                    t_start = 1'b1;
                    state_d = ST_COUNTING;
                end
            end
            ST_COUNTING: begin
                if (!gate) begin
                    t_halt  = 1'b1;
                    state_d = ST_STOPPED;
                end else if (tick_stb) begin
                    if (cnt_q == ONE) begin
                        t_expire = 1'b1;
                    end else begin
                        t_step = 1'b1;
                    end
                end
            end
        endcase
    end

    // State register and edge-detect history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            ten_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ten_q   <= tick_en;
        end
    end

    // Counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (t_start || t_expire) begin
            cnt_q <= reload;
        end else if (t_step) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Outputs
    always_comb begin
        running = (state_q == ST_COUNTING);
        expire  = t_expire;
        count   = cnt_q;
    end

endmodule

// File: rtl/tick_pending_reg.sv
module tick_pending_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_wr,
    input  logic clr_data,
    output logic pending,
    output logic irq
);

    logic pend_q;

    // A new event outranks an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_evt) begin
            pend_q <= 1'b1;
        end else if (clr_wr && clr_data) begin
            pend_q <= 1'b0;
        end
    end

    assign pending = pend_q;
    assign irq     = pend_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 15,
    parameter int SEL_W      = 4,
    parameter int MIN_RELOAD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_stb,
    input  logic             master_en,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             pend_wr,
    input  logic             pend_wdata,
    output logic             tick_irq,
    output logic             tick_pending,
    output logic [CNT_W-1:0] tick_count
);

    logic             tick_stb;
    logic [CNT_W-1:0] reload_q;
    logic             running;
    logic             expire;

    tick_prescaler #(
        .PRE_W (PRE_W),
        .SEL_W (SEL_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_stb  (ref_stb),
        .div_sel  (div_sel),
        .tick_stb (tick_stb)
    );

    tick_reload_reg #(
        .CNT_W      (CNT_W),
        .MIN_RELOAD (MIN_RELOAD)
    ) u_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reload_wr),
        .wdata    (reload_wdata),
        .reload_q (reload_q)
    );

    tick_down_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .tick_en   (tick_en),
        .tick_stb  (tick_stb),
        .reload    (reload_q),
        .running   (running),
        .expire    (expire),
        .count     (tick_count)
    );

    tick_pending_reg u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (expire),
        .clr_wr   (pend_wr),
        .clr_data (pend_wdata),
        .pending  (tick_pending),
        .irq      (tick_irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W      = 16,
    parameter int MIN_RELOAD = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_en,
    input logic             tick_en,
    input logic             pend_wr,
    input logic             pend_wdata,
    input logic             tick_stb,
    input logic             running,
    input logic [CNT_W-1:0] reload_val,
    input logic             tick_pending,
    input logic [CNT_W-1:0] tick_count
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

    // R3: the stored reload never holds a refused value
    p_reload_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_val == '0) || (reload_val > FLOOR));

    // R4: a running counter never shows zero
    p_run_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (tick_count != '0));

    // R5: with the master enable low the count cannot move
    p_hold_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> $stable(tick_count));

    // R2: an ordinary tick while running steps down by exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && master_en && tick_en && tick_stb && tick_count != ONE)
        |=> (tick_count == $past(tick_count) - ONE));

    // R7: a clear with no expiry possible drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && pend_wdata && tick_count != ONE) |=> !tick_pending);

    // R6: the flag stays until acknowledged
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_pending && !(pend_wr && pend_wdata)) |=> tick_pending);

    // R6: the flag rises only from an expiry
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_pending && tick_count != ONE) |=> !tick_pending);

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W      (CNT_W),
    .MIN_RELOAD (MIN_RELOAD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_en    (master_en),
    .tick_en      (tick_en),
    .pend_wr      (pend_wr),
    .pend_wdata   (pend_wdata),
    .tick_stb     (tick_stb),
    .running      (running),
    .reload_val   (reload_q),
    .tick_pending (tick_pending),
    .tick_count   (tick_count)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_stb = 1'b0;
    logic             master_en = 1'b0;
    logic             tick_en = 1'b0;
    logic [3:0]       div_sel = '0;
    logic             reload_wr = 1'b0;
    logic [CNT_W-1:0] reload_wdata = '0;
    logic             pend_wr = 1'b0;
    logic             pend_wdata = 1'b0;
    wire              tick_irq;
    wire              tick_pending;
    wire [CNT_W-1:0]  tick_count;

    always #2 clk = ~clk;

    tick_timer u_tick_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_stb      (ref_stb),
        .master_en    (master_en),
        .tick_en      (tick_en),
        .div_sel      (div_sel),
        .reload_wr    (reload_wr),
        .reload_wdata (reload_wdata),
        .pend_wr      (pend_wr),
        .pend_wdata   (pend_wdata),
        .tick_irq     (tick_irq),
        .tick_pending (tick_pending),
        .tick_count   (tick_count)
    );

    // Reference strobe generator: 0 = every cycle, 1 = every third, 2 = pseudo-random
    int       ref_mode = 0;
    int       ref_cyc  = 0;
    bit [15:0] ref_lfsr = 16'hACE1;
    always @(negedge clk) begin
        ref_cyc  <= ref_cyc + 1;
        ref_lfsr <= {ref_lfsr[14:0], ref_lfsr[15] ^ ref_lfsr[13] ^ ref_lfsr[12] ^ ref_lfsr[10]};
        case (ref_mode)
            0:       ref_stb <= 1'b1;
            1:       ref_stb <= (ref_cyc % 3 == 0);
            default: ref_stb <= ref_lfsr[0];
        endcase
    end

    // Cycle model written from the requirements
    int unsigned      m_refs;
    bit               m_run, m_pend, m_ten_q;
    logic [CNT_W-1:0] m_cnt, m_reload;
    always @(posedge clk) begin : model
        bit stb;
        bit fire;
        if (!rst_n) begin
            m_refs = 0; m_run = 0; m_pend = 0; m_ten_q = 0;
            m_cnt = '0; m_reload = '0;
        end else begin
            stb  = ref_stb && (((m_refs + 1) & ((32'd1 << div_sel) - 1)) == 0);
            fire = 0;
            if (ref_stb) m_refs = m_refs + 1;
            if (!m_run) begin
                if (tick_en && !m_ten_q && master_en && m_reload != 0) begin
                    m_run = 1;
                    m_cnt = m_reload;
                end
            end else if (!(master_en && tick_en)) begin
                m_run = 0;
            end else if (stb) begin
                if (m_cnt == 1) begin
                    m_cnt = m_reload;
                    fire  = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (fire) m_pend = 1;
            else if (pend_wr && pend_wdata) m_pend = 0;
            m_ten_q = tick_en;
            if (reload_wr && reload_wdata > 2) m_reload = reload_wdata;
        end
    end

    // Scoreboard queues
    string            q_tag[$];
    logic [CNT_W-1:0] q_cnt[$];
    bit               q_pend[$];
    int               n_cmp = 0;
    int               n_bad = 0;
    bit               done  = 0;

    task automatic expect_val(string tag, logic [CNT_W-1:0] c, bit p);
        q_tag.push_back(tag);
        q_cnt.push_back(c);
        q_pend.push_back(p);
    endtask

    task automatic expect_model(string tag);
        expect_val(tag, m_cnt, m_pend);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: compares queued expectations one ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_tag.size() > 0) begin
                string            t;
                logic [CNT_W-1:0] c;
                bit               p;
                t = q_tag.pop_front();
                c = q_cnt.pop_front();
                p = q_pend.pop_front();
                n_cmp++;
                // irq is compared with the expected pending value (R9)
                if (tick_count !== c || tick_pending !== p || tick_irq !== p) begin
                    n_bad++;
                    $display("FAIL %s: count=%0d exp %0d, pending=%0b exp %0b, irq=%0b exp %0b",
                             t, tick_count, c, tick_pending, p, tick_irq, p);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1: actual run still busy, expected finished");
            report();
            $finish;
        end
    end

    initial begin
        bit [15:0]        lf;
        logic [CNT_W-1:0] held;
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_val("R1 reset state", 0, 0);
        expect_model("R1 model");

        // R3 refused values, R4 no start with zero reload
        master_en    = 1'b1;
        reload_wr    = 1'b1;
        reload_wdata = 2;
        step(1);
        reload_wdata = 1;
        step(1);
        reload_wr = 1'b0;
        tick_en   = 1'b1;
        step(3);
        expect_val("R4 R3 zero reload no start", 0, 0);
        tick_en = 1'b0;
        step(1);

        // Load 5, then try 2 which must be refused
        reload_wr    = 1'b1;
        reload_wdata = 5;
        step(1);
        reload_wdata = 2;
        step(1);
        reload_wr = 1'b0;
        tick_en   = 1'b1;
        step(1);
        expect_val("R3 R4 load on rising enable", 5, 0);
        step(1);
        expect_val("R2 step every strobe", 4, 0);
        step(3);
        expect_val("R6 reaches one", 1, 0);
        step(1);
        expect_val("R6 expiry reload and flag", 5, 1);

        // R7 write of zero ignored, write of one clears
        pend_wr    = 1'b1;
        pend_wdata = 1'b0;
        step(1);
        expect_val("R7 zero write ignored", 4, 1);
        pend_wdata = 1'b1;
        step(1);
        expect_val("R7 clear", 3, 0);
        pend_wr = 1'b0;

        // R8 clear in the expiry cycle
        step(2);
        expect_val("R8 setup", 1, 0);
        pend_wr    = 1'b1;
        pend_wdata = 1'b1;
        step(1);
        expect_val("R8 set wins", 5, 1);
        step(1);
        expect_val("R7 clear after collision", 4, 0);
        pend_wr = 1'b0;

        // R10 reload write while running
        reload_wr    = 1'b1;
        reload_wdata = 9;
        step(1);
        reload_wr = 1'b0;
        expect_val("R10 count unaffected", 3, 0);
        step(2);
        expect_val("R10 countdown", 1, 0);
        step(1);
        expect_val("R10 new reload used", 9, 1);
        pend_wr    = 1'b1;
        pend_wdata = 1'b1;
        step(1);
        pend_wr = 1'b0;
        expect_val("R7 clear again", 8, 0);

        // R5 tick enable low
        tick_en = 1'b0;
        step(6);
        expect_val("R5 tick_en low holds", 8, 0);
        tick_en = 1'b1;
        step(1);
        expect_val("R4 restart on edge", 9, 0);
        master_en = 1'b0;
        step(5);
        expect_val("R5 master low holds", 9, 0);
        master_en = 1'b1;
        step(4);
        expect_val("R4 master rise alone no start", 9, 0);
        tick_en   = 1'b0;
        master_en = 1'b0;
        step(1);
        tick_en = 1'b1;
        step(2);
        master_en = 1'b1;
        step(3);
        expect_val("R4 edge while master low ignored", 9, 0);
        held = tick_count;
        step(2);
        expect_val("R5 still stopped", held, 0);

        // R2 divided rates
        tick_en = 1'b0;
        div_sel = 4'd3;
        step(1);
        tick_en = 1'b1;
        for (int i = 0; i < 150; i++) begin
            step(1);
            expect_model("R2 divide by 8");
        end
        ref_mode = 1;
        div_sel  = 4'd1;
        for (int i = 0; i < 150; i++) begin
            step(1);
            expect_model("R2 sparse strobes divide by 2");
        end

        // Mixed pseudo-random traffic
        ref_mode = 2;
        lf       = 16'h1D2B;
        for (int i = 0; i < 2000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            master_en    = (lf[15:13] != 3'b000);
            if (lf[3:0] == 4'h0) tick_en = ~tick_en;
            reload_wr    = (lf[7:5] == 3'b000);
            reload_wdata = CNT_W'(lf[11:8]);
            pend_wr      = lf[4];
            pend_wdata   = lf[9];
            div_sel      = {2'b00, lf[1:0]};
            step(1);
            expect_model("R6 R8 mixed traffic");
        end
        reload_wr = 1'b0;
        pend_wr   = 1'b0;
        step(3);
        done = 1;
        report();
        $finish;
    end

endmodule